// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Lamp Test and Blanking

This block turns one 4-bit binary-coded-decimal digit into the seven segment drives of a common-anode display. Every output is active-low: a segment that should glow is driven to 0, and a dark segment is driven to 1. One copy is placed per display digit, and it takes its input straight from that digit's decade counter.

Two active-low override inputs sit on top of the decoding. The lamp-test input lights all seven segments so that a dead LED can be found. The blanking input darkens the whole digit, for example to hide a leading zero. Blanking wins over lamp test. Input codes above nine are not decimal digits, so the block shows them as a dark digit. The decimal point, digit multiplexing and the analogue drive network are outside this block.

The logic is purely combinational. All 64 combinations of code and override inputs give a defined output.

Top module: `bcd_seg_decoder`

## Requirements
- R1: The output bus `seg_n` is ordered {g,f,e,d,c,b,a}, with `seg_n[0]` = segment a, and is active-low (0 = lit). With both overrides inactive (high), codes 0..9 give the following lit segments: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg. So 0 gives 7'b1000000 and 8 gives 7'b0000000.
- R2: With both overrides inactive, codes 10 to 15 drive every output to 1 (7'b1111111).
- R3: With `lamp_test_n` = 0 and `blank_n` = 1, every output is 0 (7'b0000000) for all 16 codes, including invalid ones.
- R4: With `blank_n` = 0 and `lamp_test_n` = 1, every output is 1 (7'b1111111) for all 16 codes.
- R5: With `blank_n` = 0 and `lamp_test_n` = 0, blanking takes priority and every output is 1.
- R6: The outputs depend only on the present inputs. A change on any input shows at `seg_n` in the same time step with no clock. Each of the 64 input combinations gives a fully defined (non-X) value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_bcd | input | 4 | BCD digit code; values 0..9 are valid |
| lamp_test_n | input | 1 | Active-low lamp test; lights all segments |
| blank_n | input | 1 | Active-low blanking; darkens all segments, highest priority |
| seg_n | output | 7 | Active-low segment drives {g,f,e,d,c,b,a} |

## Verification
The ten valid digits are applied with both overrides idle. This separates a wrong glyph, a swapped bit order or an inverted polarity, because each digit has a distinct pattern, 0 and 8 differ only in g, and 6 and 9 depend on their tail segments. The six invalid codes are then applied, so that an incomplete case decode or a wrap of the code into 0..5 shows as lit segments. Each override is tried alone across all 16 codes. Both overrides are then asserted together, which exposes a reversed priority. A final sweep of all 64 combinations compares against a table the bench builds segment by segment, and detects any stale value that would point to a latch.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;

  localparam int unsigned SEG_W   = 7;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned MAX_DIG = 9;

  typedef logic [SEG_W-1:0]  seg_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam seg_vec_t SEG_NONE = '0;
  localparam seg_vec_t SEG_ALL  = '1;

  // Active-high glyph, bit order {g,f,e,d,c,b,a}
  function automatic seg_vec_t digit_glyph(input code_t code);
    seg_vec_t g;
    case (code)
      4'd0:    g = 7'b0111111;
      4'd1:    g = 7'b0000110;
      4'd2:    g = 7'b1011011;
      4'd3:    g = 7'b1001111;
      4'd4:    g = 7'b1100110;
      4'd5:    g = 7'b1101101;
      4'd6:    g = 7'b1111101;
      4'd7:    g = 7'b0000111;
      4'd8:    g = 7'b1111111;
      4'd9:    g = 7'b1101111;
      default: g = SEG_NONE;
    endcase
    return g;
  endfunction

  function automatic logic code_is_decimal(input code_t code);
    return (code <= code_t'(MAX_DIG));
  endfunction

  // Priority: blank > lamp test > glyph
  function automatic seg_vec_t apply_overrides(input seg_vec_t glyph,
                                               input logic blank_req,
                                               input logic lamp_req);
    seg_vec_t r;
    if (blank_req)     r = SEG_NONE;
    else if (lamp_req) r = SEG_ALL;
    else               r = glyph;
    return r;
  endfunction

endpackage

// File: rtl/bcd_seg_glyph.sv
module bcd_seg_glyph
  import bcd_seg_pkg::*;
(
  input  code_t    code_i,
  output seg_vec_t glyph_o,
  output logic     valid_o
);
  always_comb begin
    valid_o = code_is_decimal(code_i);
    glyph_o = valid_o ? digit_glyph(code_i) : SEG_NONE;
  end
endmodule

// File: rtl/bcd_seg_override.sv
module bcd_seg_override
  import bcd_seg_pkg::*;
(
  input  seg_vec_t glyph_i,
  input  logic     lamp_test_n_i,
  input  logic     blank_n_i,
  output seg_vec_t lit_o,
  output logic     blank_req_o,
  output logic     lamp_req_o
);
  always_comb begin
    blank_req_o = ~blank_n_i;
    lamp_req_o  = ~lamp_test_n_i;
    lit_o       = apply_overrides(glyph_i, blank_req_o, lamp_req_o);
  end
endmodule

// File: rtl/bcd_seg_drive.sv
module bcd_seg_drive
  import bcd_seg_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
)(
  input  seg_vec_t lit_i,
  output seg_vec_t pin_o
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign pin_o = ~lit_i;
    end else begin : g_high
      assign pin_o = lit_i;
    end
  endgenerate
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [3:0] digit_bcd,
  input  logic       lamp_test_n,
  input  logic       blank_n,
  output logic [6:0] seg_n
);
  seg_vec_t glyph;
  seg_vec_t lit;
  logic     code_valid;
  logic     blank_req;
  logic     lamp_req;
  seg_vec_t pins;

  bcd_seg_glyph u_glyph (
    .code_i  (digit_bcd),
    .glyph_o (glyph),
    .valid_o (code_valid)
  );

  bcd_seg_override u_ovr (
    .glyph_i       (glyph),
    .lamp_test_n_i (lamp_test_n),
    .blank_n_i     (blank_n),
    .lit_o         (lit),
    .blank_req_o   (blank_req),
    .lamp_req_o    (lamp_req)
  );

  bcd_seg_drive #(.ACTIVE_LOW(1'b1)) u_drive (
    .lit_i (lit),
    .pin_o (pins)
  );

  assign seg_n = pins;
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk (
  input logic [3:0] digit_bcd,
  input logic       lamp_test_n,
  input logic       blank_n,
  input logic [6:0] seg_n,
  input logic       code_valid,
  input logic       blank_req,
  input logic       lamp_req
);
  always_comb begin
    if (!$isunknown({digit_bcd, lamp_test_n, blank_n})) begin
      // R6
      no_x_out_chk: assert (!$isunknown(seg_n));
      // R4
      blank_dark_chk: assert (!(blank_n == 1'b0 && lamp_test_n == 1'b1) || seg_n == 7'h7F);
      // R5
      blank_wins_chk: assert (!(blank_req && lamp_req) || seg_n == 7'h7F);
      // R3
      lamp_all_chk: assert (!(lamp_test_n == 1'b0 && blank_n == 1'b1) || seg_n == 7'h00);
      // R2
      invalid_dark_chk: assert (!(digit_bcd > 4'd9 && lamp_test_n && blank_n) || seg_n == 7'h7F);
      // R1
      digit_shows_chk: assert (!(code_valid && !blank_req && !lamp_req) || $countones(~seg_n) >= 2);
    end
  end
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
  .digit_bcd   (digit_bcd),
  .lamp_test_n (lamp_test_n),
  .blank_n     (blank_n),
  .seg_n       (seg_n),
  .code_valid  (code_valid),
  .blank_req   (blank_req),
  .lamp_req    (lamp_req)
);

// File: tb/bcd_seg_decoder_bench.sv
module bcd_seg_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit_bcd = 4'd0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b0;
  logic [6:0] seg_n;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_seg_decoder u_bcd_seg_decoder (
    .digit_bcd   (digit_bcd),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .seg_n       (seg_n)
  );

  // Per-segment digit masks: bit d set when the segment glows for digit d
  function automatic logic [6:0] model(input int code, input logic lt_n, input logic bl_n);
    logic [9:0] on_mask [7];
    logic [6:0] lit;
    on_mask[0] = 10'b11_1110_1101; // a: 0,2,3,5,6,7,8,9
    on_mask[1] = 10'b11_1001_1111; // b: 0,1,2,3,4,7,8,9
    on_mask[2] = 10'b11_1111_1011; // c: all but 2
    on_mask[3] = 10'b11_0110_1101; // d: 0,2,3,5,6,8,9
    on_mask[4] = 10'b01_0100_0101; // e: 0,2,6,8
    on_mask[5] = 10'b11_0111_0001; // f: 0,4,5,6,8,9
    on_mask[6] = 10'b11_0111_1100; // g: 2,3,4,5,6,8,9
    for (int s = 0; s < 7; s++)
      lit[s] = (code <= 9) ? on_mask[s][code] : 1'b0;
    if (!bl_n)      return 7'h7F;
    else if (!lt_n) return 7'h00;
    else            return ~lit;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    n_run++;
    if (seg_n !== exp) begin
      n_fail++;
      $display("FAIL %s code=%0d lt_n=%b bl_n=%b got=%b exp=%b",
               req, digit_bcd, lamp_test_n, blank_n, seg_n, exp);
    end
  endtask

  task automatic apply(input int code, input logic lt_n, input logic bl_n);
    @(negedge clk);
    digit_bcd = 4'(code); lamp_test_n = lt_n; blank_n = bl_n;
    #1;
  endtask

  task automatic t_quiescent();
    apply(0, 1'b1, 1'b0);
    check("R4", 7'b1111111);
  endtask

  task automatic t_digits();
    apply(0, 1'b1, 1'b1); check("R1", 7'b1000000);
    apply(8, 1'b1, 1'b1); check("R1", 7'b0000000);
    apply(1, 1'b1, 1'b1); check("R1", 7'b1111001);
    apply(6, 1'b1, 1'b1); check("R1", 7'b0000010);
    apply(9, 1'b1, 1'b1); check("R1", 7'b0010000);
    apply(7, 1'b1, 1'b1); check("R1", 7'b1111000);
    for (int c = 0; c < 10; c++) begin
      apply(c, 1'b1, 1'b1); check("R1", model(c, 1'b1, 1'b1));
    end
  endtask

  task automatic t_invalid();
    for (int c = 10; c < 16; c++) begin
      apply(c, 1'b1, 1'b1); check("R2", 7'b1111111);
    end
  endtask

  task automatic t_lamp();
    for (int c = 0; c < 16; c++) begin
      apply(c, 1'b0, 1'b1); check("R3", 7'b0000000);
    end
  endtask

  task automatic t_blank();
    for (int c = 0; c < 16; c++) begin
      apply(c, 1'b1, 1'b0); check("R4", 7'b1111111);
    end
  endtask

  task automatic t_both();
    for (int c = 0; c < 16; c++) begin
      apply(c, 1'b0, 1'b0); check("R5", 7'b1111111);
    end
  endtask

  // R6: same-step response, alternating so a held value would be caught
  task automatic t_sweep();
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++) begin
        apply(c, m[0], m[1]);
        check("R6", model(c, m[0], m[1]));
        digit_bcd = 4'(15 - c); #1;
        check("R6", model(15 - c, m[0], m[1]));
      end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_quiescent();
    t_digits();
    t_invalid();
    t_lamp();
    t_blank();
    t_both();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule